// File: doc/BRIEF.md
# SCSI Bus Arbitration Sequencer

This block is the initiator-side engine that gains control of a SCSI bus and, in its full mode, selects a target device. Software writes a control word that holds a two-bit mode field and a start bit. The start bit launches one sequence. A set of sticky status flags reports how the sequence ended. The flags are cleared when the status is read. On the bus side, each of BSY, SEL and the eight data lines has a separate output enable and a separate sensed input. The bench models the wired bus as the OR of every driver.

Mode `00` (simple) makes a single arbitration attempt. The block waits for bus free, drives BSY and its own ID bit, and holds them for the arbitration delay. It then captures the data lines so that the CPU can do the final priority check. Mode `11` (full) retries on every bus free until it wins. It then holds SEL for the bus-clear plus bus-settle delay and presents the target ID together with its own ID. It reports either completion or a timeout.

The controller has these states: IDLE, WAIT_FREE, ARBITRATE, SEL_DELAY, SELECTING, SEL_RELEASE and CONNECTED. Its transitions are:
- start: IDLE to WAIT_FREE.
- bus-free: WAIT_FREE to ARBITRATE.
- simple-lost: ARBITRATE to IDLE.
- simple-done: ARBITRATE to IDLE.
- full-retry: ARBITRATE to WAIT_FREE.
- won: ARBITRATE to SEL_DELAY.
- settle-done: SEL_DELAY to SELECTING.
- answered: SELECTING to SEL_RELEASE.
- timeout: SELECTING to IDLE.
- released: SEL_RELEASE to CONNECTED.
- disconnect: CONNECTED to IDLE.

Top module: `scsi_arb_seq`

## Requirements
- R1: After reset, the mode field reads `11`, the start bit reads 0, every status flag is 0, the capture register is 0, and no bus line is driven.
- R2: A start request with a reserved mode (`01` or `10`) launches nothing. The start bit stays 0 and BSY is never driven.
- R3: BSY and the own ID bit (data bit number `own_id`) are driven only after BSY and SEL have both been sensed low for BUS_FREE_CYC consecutive cycles. BSY rises on the BUS_FREE_CYC-th clock edge after the write, or after SEL is released. While BSY is driven, no other data bit is driven.
- R4: In simple mode, SEL sensed during arbitration releases BSY and the ID bit on the next edge, sets the lost flag and ends the sequence.
- R5: In simple mode without loss, BSY is held for ARB_DLY_CYC cycles and then released. The data lines are captured into `arb_ids` and no won flag is set.
- R6: In full mode, SEL during arbitration, or any data bit numbered above `own_id` at the end of the arbitration delay, releases the bus and re-enters bus-free waiting. Lower-numbered bits are ignored. No flag is set and the start bit stays 1.
- R7: On a full-mode win, the won flag is set, and BSY, SEL and the own ID are driven for CLR_SETTLE_CYC cycles. After that, BSY is released and SEL is driven with the own and target ID bits.
- R8: A target that asserts BSY during selection sets the done flag. SEL and the data lines are held for REL_SETTLE_CYC more cycles and then released. The connection lasts until BSY drops.
- R9: If no answer arrives within SEL_TMO_CYC cycles of selection, the timeout flag is set and every bus line is released.
- R10: The connected status is 1 while BSY is driven, during SEL_RELEASE and during CONNECTED. A start request while connected is ignored.
- R11: A status read returns the flags and clears them after that cycle. A flag that is set in the same cycle as the read stays set.
- R12: The start bit clears itself on the edge that ends the sequence, whether by loss, simple completion, timeout or reaching CONNECTED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_mode | input | 2 | Mode field written |
| cfg_start | input | 1 | Start bit written |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| own_id | input | ID_W | Own bus ID number |
| dest_id | input | ID_W | Target bus ID number |
| bsy_in | input | 1 | Sensed BSY |
| sel_in | input | 1 | Sensed SEL |
| data_in | input | 2**ID_W | Sensed data lines |
| bsy_oe | output | 1 | Drive BSY |
| sel_oe | output | 1 | Drive SEL |
| data_oe | output | 2**ID_W | Drive each data line |
| ctl_mode | output | 2 | Mode field readback |
| ctl_start | output | 1 | Start bit readback |
| st_lost | output | 1 | Lost arbitration flag |
| st_won | output | 1 | Won arbitration flag |
| st_done | output | 1 | Selection complete flag |
| st_tmo | output | 1 | Selection timeout flag |
| st_conn | output | 1 | Connected status |
| arb_ids | output | 2**ID_W | Data lines captured at the end of simple arbitration |

## Verification
A status flag can be set by the sequencer in the same cycle in which a status read clears it. The bench provokes this by raising an external SEL during simple arbitration on the same cycle that it pulses the read strobe. The scoreboard then expects three things: the read shows the flags from before that edge, the next read shows the lost flag set, and the read after that shows it cleared. The start bit also has two sources in one cycle, a new write and a sequence ending. Writes are refused while a sequence runs, and the bench checks this through a start request made while connected.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_ARBITRATE,
        ST_SEL_DELAY,
        ST_SELECTING,
        ST_SEL_RELEASE,
        ST_CONNECTED
    } arb_state_e;

    localparam logic [1:0] MODE_SIMPLE = 2'b00;
    localparam logic [1:0] MODE_FULL   = 2'b11;

    function automatic logic mode_ok(input logic [1:0] m);
        return (m == MODE_SIMPLE) || (m == MODE_FULL);
    endfunction

endpackage

// File: rtl/scsi_arb_timer.sv
module scsi_arb_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    // Saturating up-counter; restarted whenever the controller asks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scsi_arb_prio.sv
module scsi_arb_prio #(
    parameter int ID_W = 3
) (
    input  logic [ID_W-1:0]      own_id,
    input  logic [(1<<ID_W)-1:0] bus_data,
    output logic [(1<<ID_W)-1:0] own_mask,
    output logic                 higher_seen
);

    localparam int BUS_W = 1 << ID_W;

    logic [BUS_W-1:0] hi_mask;

    // Per-line decode: own line, and lines that outrank it.
    for (genvar g = 0; g < BUS_W; g++) begin : g_line
        assign own_mask[g] = (own_id == ID_W'(g));
        assign hi_mask[g]  = (ID_W'(g) > own_id);
    end

    assign higher_seen = |(bus_data & hi_mask);

endmodule

// File: rtl/scsi_arb_fsm.sv
module scsi_arb_fsm
    import scsi_arb_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int BUS_FREE_CYC   = 4,
    parameter int ARB_DLY_CYC    = 6,
    parameter int CLR_SETTLE_CYC = 150,
    parameter int SEL_TMO_CYC    = 2000,
    parameter int REL_SETTLE_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [1:0]       mode,
    input  logic             bsy_in,
    input  logic             sel_in,
    input  logic             higher_seen,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output arb_state_e       state,
    output logic             bsy_oe,
    output logic             sel_oe,
    output logic             drv_own,
    output logic             drv_dest,
    output logic             connected,
    output logic             set_lost,
    output logic             set_won,
    output logic             set_done,
    output logic             set_tmo,
    output logic             snap_ids,
    output logic             seq_done
);

    localparam logic [CNT_W-1:0] FREE_LAST = CNT_W'(BUS_FREE_CYC - 1);
    localparam logic [CNT_W-1:0] ARB_LAST  = CNT_W'(ARB_DLY_CYC - 1);
    localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(CLR_SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(SEL_TMO_CYC - 1);
    localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(REL_SETTLE_CYC - 1);

    arb_state_e nxt;
    logic       bus_free;
    logic       simple;

    assign bus_free = !bsy_in && !sel_in;
    assign simple   = (mode == MODE_SIMPLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions and event pulses
    always_comb begin
        nxt      = state;
        set_lost = 1'b0;
        set_won  = 1'b0;
        set_done = 1'b0;
        set_tmo  = 1'b0;
        snap_ids = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) nxt = ST_WAIT_FREE;
            end
            ST_WAIT_FREE: begin
                if (bus_free && cnt == FREE_LAST) nxt = ST_ARBITRATE;
            end
            ST_ARBITRATE: begin
                if (sel_in) begin
                    if (simple) begin
                        nxt      = ST_IDLE;
                        set_lost = 1'b1;
                    end else begin
                        nxt = ST_WAIT_FREE;
                    end
                end else if (cnt == ARB_LAST) begin
                    if (simple) begin
                        nxt      = ST_IDLE;
                        snap_ids = 1'b1;
                    end else if (higher_seen) begin
                        nxt = ST_WAIT_FREE;
                    end else begin
                        nxt     = ST_SEL_DELAY;
                        set_won = 1'b1;
                    end
                end
            end
            ST_SEL_DELAY: begin
                if (cnt == CLR_LAST) nxt = ST_SELECTING;
            end
            ST_SELECTING: begin
                if (bsy_in) begin
                    nxt      = ST_SEL_RELEASE;
                    set_done = 1'b1;
                end else if (cnt == TMO_LAST) begin
                    nxt     = ST_IDLE;
                    set_tmo = 1'b1;
                end
            end
            ST_SEL_RELEASE: begin
                if (cnt == REL_LAST) nxt = ST_CONNECTED;
            end
            ST_CONNECTED: begin
                if (!bsy_in) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign cnt_clr  = (nxt != state) || (state == ST_WAIT_FREE && !bus_free);
    assign seq_done = (state != ST_IDLE) && (state != ST_CONNECTED) &&
                      ((nxt == ST_IDLE) || (nxt == ST_CONNECTED));

    // Bus drive and connection status, decoded from the state
    always_comb begin
        bsy_oe    = 1'b0;
        sel_oe    = 1'b0;
        drv_own   = 1'b0;
        drv_dest  = 1'b0;
        connected = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT_FREE: ;
            ST_ARBITRATE: begin
                bsy_oe    = 1'b1;
                drv_own   = 1'b1;
                connected = 1'b1;
            end
            ST_SEL_DELAY: begin
                bsy_oe    = 1'b1;
                sel_oe    = 1'b1;
                drv_own   = 1'b1;
                connected = 1'b1;
            end
            ST_SELECTING: begin
                sel_oe   = 1'b1;
                drv_own  = 1'b1;
                drv_dest = 1'b1;
            end
            ST_SEL_RELEASE: begin
                sel_oe    = 1'b1;
                drv_own   = 1'b1;
                drv_dest  = 1'b1;
                connected = 1'b1;
            end
            ST_CONNECTED: begin
                connected = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scsi_arb_seq.sv
module scsi_arb_seq
    import scsi_arb_pkg::*;
#(
    parameter int ID_W           = 3,
    parameter int BUS_FREE_CYC   = 4,
    parameter int ARB_DLY_CYC    = 6,
    parameter int CLR_SETTLE_CYC = 150,
    parameter int SEL_TMO_CYC    = 2000,
    parameter int REL_SETTLE_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_start,
    input  logic                 stat_rd,
    input  logic [ID_W-1:0]      own_id,
    input  logic [ID_W-1:0]      dest_id,
    input  logic                 bsy_in,
    input  logic                 sel_in,
    input  logic [(1<<ID_W)-1:0] data_in,
    output logic                 bsy_oe,
    output logic                 sel_oe,
    output logic [(1<<ID_W)-1:0] data_oe,
    output logic [1:0]           ctl_mode,
    output logic                 ctl_start,
    output logic                 st_lost,
    output logic                 st_won,
    output logic                 st_done,
    output logic                 st_tmo,
    output logic                 st_conn,
    output logic [(1<<ID_W)-1:0] arb_ids
);

    localparam int BUS_W   = 1 << ID_W;
    localparam int MAX_A   = (BUS_FREE_CYC > ARB_DLY_CYC) ? BUS_FREE_CYC : ARB_DLY_CYC;
    localparam int MAX_B   = (CLR_SETTLE_CYC > SEL_TMO_CYC) ? CLR_SETTLE_CYC : SEL_TMO_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > REL_SETTLE_CYC) ? MAX_C : REL_SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    arb_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             go;
    logic             drv_own, drv_dest;
    logic             set_lost, set_won, set_done, set_tmo;
    logic             snap_ids, seq_done;
    logic             higher_seen;
    logic [BUS_W-1:0] own_mask, dest_mask;

    // A start is taken only from rest, with a defined mode, off the bus.
    assign go = cfg_wr && cfg_start && !ctl_start && mode_ok(cfg_mode) &&
                !st_conn && (state == ST_IDLE);

    // Control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_mode  <= MODE_FULL;
            ctl_start <= 1'b0;
        end else begin
            if (seq_done) ctl_start <= 1'b0;
            if (cfg_wr && !ctl_start) begin
                ctl_mode <= cfg_mode;
                if (go) ctl_start <= 1'b1;
            end
        end
    end

    // Sticky status flags: a new event outranks the read clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_lost <= 1'b0;
            st_won  <= 1'b0;
            st_done <= 1'b0;
            st_tmo  <= 1'b0;
        end else begin
            st_lost <= set_lost || (st_lost && !stat_rd);
            st_won  <= set_won  || (st_won  && !stat_rd);
            st_done <= set_done || (st_done && !stat_rd);
            st_tmo  <= set_tmo  || (st_tmo  && !stat_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_ids <= '0;
        end else if (snap_ids) begin
            arb_ids <= data_in;
        end
    end

    assign dest_mask = BUS_W'(1) << dest_id;
    assign data_oe   = ({BUS_W{drv_own}} & own_mask) | ({BUS_W{drv_dest}} & dest_mask);

    scsi_arb_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    scsi_arb_prio #(.ID_W(ID_W)) u_prio (
        .own_id      (own_id),
        .bus_data    (data_in),
        .own_mask    (own_mask),
        .higher_seen (higher_seen)
    );

    scsi_arb_fsm #(
        .CNT_W          (CNT_W),
        .BUS_FREE_CYC   (BUS_FREE_CYC),
        .ARB_DLY_CYC    (ARB_DLY_CYC),
        .CLR_SETTLE_CYC (CLR_SETTLE_CYC),
        .SEL_TMO_CYC    (SEL_TMO_CYC),
        .REL_SETTLE_CYC (REL_SETTLE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .mode        (ctl_mode),
        .bsy_in      (bsy_in),
        .sel_in      (sel_in),
        .higher_seen (higher_seen),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .state       (state),
        .bsy_oe      (bsy_oe),
        .sel_oe      (sel_oe),
        .drv_own     (drv_own),
        .drv_dest    (drv_dest),
        .connected   (st_conn),
        .set_lost    (set_lost),
        .set_won     (set_won),
        .set_done    (set_done),
        .set_tmo     (set_tmo),
        .snap_ids    (snap_ids),
        .seq_done    (seq_done)
    );

endmodule

// File: rtl/scsi_arb_chk.sv
module scsi_arb_chk #(
    parameter int ID_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bsy_in,
    input logic                 sel_in,
    input logic                 bsy_oe,
    input logic                 sel_oe,
    input logic [(1<<ID_W)-1:0] data_oe,
    input logic [ID_W-1:0]      own_id,
    input logic [ID_W-1:0]      dest_id,
    input logic [1:0]           ctl_mode,
    input logic                 ctl_start,
    input logic                 st_conn,
    input logic                 st_tmo
);

    localparam int BUS_W = 1 << ID_W;

    // R3
    bus_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_oe) |-> $past(!bsy_in && !sel_in));

    // R3
    own_line_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsy_oe |-> (data_oe == (BUS_W'(1) << own_id)));

    // R7
    sel_both_ids_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_oe && !bsy_oe) |-> (data_oe == ((BUS_W'(1) << own_id) | (BUS_W'(1) << dest_id))));

    // R10
    conn_when_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bsy_oe |-> st_conn);

    // R2
    valid_mode_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_start |-> (ctl_mode == 2'b00 || ctl_mode == 2'b11));

    // R9
    tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_tmo) |-> (!bsy_oe && !sel_oe && data_oe == '0));

    // R12
    start_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_start) |-> !bsy_oe);

endmodule

bind scsi_arb_seq scsi_arb_chk #(.ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bsy_in    (bsy_in),
    .sel_in    (sel_in),
    .bsy_oe    (bsy_oe),
    .sel_oe    (sel_oe),
    .data_oe   (data_oe),
    .own_id    (own_id),
    .dest_id   (dest_id),
    .ctl_mode  (ctl_mode),
    .ctl_start (ctl_start),
    .st_conn   (st_conn),
    .st_tmo    (st_tmo)
);

// File: tb/tb_scsi_arb_seq.sv
`timescale 1ns/1ps
module tb_scsi_arb_seq;

    localparam int ID_W = 3;
    localparam int BF   = 4;
    localparam int ARB  = 6;
    localparam int CLR  = 150;
    localparam int TMO  = 2000;
    localparam int REL  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_start = 1'b0, stat_rd = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [ID_W-1:0] own_id = 3'd5, dest_id = 3'd2;
    logic ext_bsy = 1'b0, ext_sel = 1'b0;
    logic [7:0] ext_data = 8'h00;
    logic bsy_in, sel_in;
    logic [7:0] data_in;
    logic bsy_oe, sel_oe;
    logic [7:0] data_oe, arb_ids;
    logic [1:0] ctl_mode;
    logic ctl_start, st_lost, st_won, st_done, st_tmo, st_conn;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 1'b0;

    logic [4:0] exp_q[$];
    string      req_q[$];
    logic [4:0] mon_exp, mon_got;
    string      mon_req;

    always #4 clk = ~clk;

    // Wired bus: every driver ORs onto the sensed lines.
    assign bsy_in  = bsy_oe | ext_bsy;
    assign sel_in  = sel_oe | ext_sel;
    assign data_in = data_oe | ext_data;

    scsi_arb_seq #(
        .ID_W(ID_W), .BUS_FREE_CYC(BF), .ARB_DLY_CYC(ARB),
        .CLR_SETTLE_CYC(CLR), .SEL_TMO_CYC(TMO), .REL_SETTLE_CYC(REL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_start(cfg_start), .stat_rd(stat_rd), .own_id(own_id),
        .dest_id(dest_id), .bsy_in(bsy_in), .sel_in(sel_in),
        .data_in(data_in), .bsy_oe(bsy_oe), .sel_oe(sel_oe),
        .data_oe(data_oe), .ctl_mode(ctl_mode), .ctl_start(ctl_start),
        .st_lost(st_lost), .st_won(st_won), .st_done(st_done),
        .st_tmo(st_tmo), .st_conn(st_conn), .arb_ids(arb_ids)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", r, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected flags {lost,won,done,tmo,conn}.
    task automatic read_status(input string r, input logic [4:0] e);
        exp_q.push_back(e);
        req_q.push_back(r);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic write_ctl(input logic [1:0] m, input logic s);
        cfg_mode  = m;
        cfg_start = s;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        cfg_start = 1'b0;
    endtask

    task automatic wait_bsy(input string r);
        int i;
        i = 0;
        while (!bsy_oe && i < 500) begin
            @(negedge clk);
            i++;
        end
        chk(r, bsy_oe, 1);
    endtask

    // Monitor side of the scoreboard
    always begin
        @(negedge clk);
        #1;
        if (stat_rd) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11: read with nothing expected, got %b expected none",
                         {st_lost, st_won, st_done, st_tmo, st_conn});
            end else begin
                mon_exp = exp_q.pop_front();
                mon_req = req_q.pop_front();
                mon_got = {st_lost, st_won, st_done, st_tmo, st_conn};
                if (mon_got !== mon_exp) begin
                    n_fail++;
                    $display("FAIL %s: status got %b expected %b", mon_req, mon_got, mon_exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mode", ctl_mode, 2'b11);
        chk("R1 start", ctl_start, 0);
        chk("R1 drive", {bsy_oe, sel_oe, data_oe}, 0);
        chk("R1 capture", arb_ids, 0);
        read_status("R1", 5'b00000);

        // R2 reserved modes launch nothing
        write_ctl(2'b01, 1'b1);
        chk("R2 start 01", ctl_start, 0);
        chk("R2 mode 01", ctl_mode, 2'b01);
        repeat (8) @(negedge clk);
        chk("R2 no bsy 01", bsy_oe, 0);
        write_ctl(2'b10, 1'b1);
        chk("R2 start 10", ctl_start, 0);
        repeat (8) @(negedge clk);
        chk("R2 no bsy 10", bsy_oe, 0);

        // R3 / R5 simple arbitration, exact bus-free count
        write_ctl(2'b00, 1'b1);
        for (int k = 1; k <= BF; k++) begin
            @(negedge clk);
            chk("R3 bsy timing", bsy_oe, (k == BF) ? 1 : 0);
        end
        chk("R3 own line", data_oe, 8'h20);
        chk("R10 conn in arb", st_conn, 1);
        ext_data = 8'h80;
        repeat (ARB - 1) @(negedge clk);
        chk("R5 still arbitrating", bsy_oe, 1);
        @(negedge clk);
        chk("R5 released", {bsy_oe, data_oe}, 0);
        chk("R5 capture", arb_ids, 8'hA0);
        chk("R12 simple end", ctl_start, 0);
        ext_data = 8'h00;
        read_status("R5", 5'b00000);

        // R4 simple mode loss
        write_ctl(2'b00, 1'b1);
        wait_bsy("R4 arb");
        ext_sel = 1'b1;
        @(negedge clk);
        chk("R4 release", {bsy_oe, data_oe}, 0);
        chk("R4 start clear", ctl_start, 0);
        ext_sel = 1'b0;
        read_status("R4", 5'b10000);

        // R11 flag set in the same cycle as the read
        write_ctl(2'b00, 1'b1);
        wait_bsy("R11 arb");
        ext_sel = 1'b1;
        read_status("R11 coincident", 5'b00001);
        ext_sel = 1'b0;
        read_status("R11 kept", 5'b10000);
        read_status("R11 cleared", 5'b00000);

        // R6 full mode retries on SEL and on a higher ID
        write_ctl(2'b11, 1'b1);
        wait_bsy("R6 arb");
        ext_sel = 1'b1;
        @(negedge clk);
        chk("R6 sel backoff", bsy_oe, 0);
        chk("R6 start held", ctl_start, 1);
        repeat (2) @(negedge clk);
        ext_sel = 1'b0;
        for (int k = 1; k <= BF; k++) begin
            @(negedge clk);
            chk("R3 retry timing", bsy_oe, (k == BF) ? 1 : 0);
        end
        ext_data = 8'h40;
        repeat (ARB - 1) @(negedge clk);
        chk("R6 higher pending", bsy_oe, 1);
        @(negedge clk);
        chk("R6 higher backoff", {bsy_oe, sel_oe}, 0);
        ext_data = 8'h00;
        wait_bsy("R6 rearb");
        ext_data = 8'h04;
        repeat (ARB) @(negedge clk);
        chk("R7 win drive", {bsy_oe, sel_oe}, 2'b11);
        chk("R7 win data", data_oe, 8'h20);
        ext_data = 8'h00;
        repeat (CLR - 1) @(negedge clk);
        chk("R7 settle hold", {bsy_oe, sel_oe}, 2'b11);
        @(negedge clk);
        chk("R7 selecting", {bsy_oe, sel_oe}, 2'b01);
        chk("R7 ids", data_oe, 8'h24);
        read_status("R7", 5'b01000);

        // R8 target answers
        ext_bsy = 1'b1;
        @(negedge clk);
        chk("R8 hold sel", {bsy_oe, sel_oe}, 2'b01);
        chk("R8 hold data", data_oe, 8'h24);
        chk("R8 conn", st_conn, 1);
        @(negedge clk);
        chk("R8 still held", sel_oe, 1);
        @(negedge clk);
        chk("R8 released", {sel_oe, data_oe}, 0);
        chk("R8 connected", st_conn, 1);
        chk("R12 connect end", ctl_start, 0);
        read_status("R8", 5'b00101);

        // R10 start ignored while connected
        write_ctl(2'b00, 1'b1);
        chk("R10 start ignored", ctl_start, 0);
        chk("R10 no drive", bsy_oe, 0);
        chk("R10 still connected", st_conn, 1);
        ext_bsy = 1'b0;
        @(negedge clk);
        chk("R8 disconnect", st_conn, 0);

        // R9 selection timeout
        write_ctl(2'b11, 1'b1);
        begin
            int i;
            i = 0;
            while (!(sel_oe && !bsy_oe) && i < 1000) begin
                @(negedge clk);
                i++;
            end
        end
        chk("R9 selecting", sel_oe, 1);
        repeat (TMO - 1) @(negedge clk);
        chk("R9 before expiry", sel_oe, 1);
        @(negedge clk);
        chk("R9 released", {bsy_oe, sel_oe, data_oe}, 0);
        chk("R12 timeout end", ctl_start, 0);
        read_status("R9", 5'b01010);

        @(negedge clk);
        chk("R11 queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule